// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block accumulates a cyclic redundancy check one bit at a time. The same engine serves the transmit side and the receive side of a synchronous serial controller: each side instantiates its own copy. A two-bit polynomial selector picks a 16-bit CCITT code, the 16-bit CRC-16 code, or the 32-bit Ethernet code. A preset selector picks an all-zeros or all-ones start value. A frame-oriented mode complements the check value before transmission and recognises a fixed residue on reception. Framing itself is detected outside the block. The surrounding logic raises `frame_start` when an opening flag or sync has been sent or recognised, and `sw_clear` whenever software asks for a reset.

Data arrives least significant bit first, one bit per `bit_valid` cycle, and enters a reflected Galois shift register. Characters are marked by `char_begin` on their first bit. The inclusion flag presented with that first bit decides whether the whole character is folded into the check. This lets a transmitter tag each character individually as it is queued. On the transmit side, `fcs_load` takes a snapshot of the value to send, and each `fcs_shift` pulse moves it out serially, highest-order term first. On the receive side, `crc_good` reports whether the running remainder is the valid one for the selected mode.

Top module: `crc_serial_engine`

## Requirements
- R1: After reset the check register is zero and `fcs_active` is low, so with `cfg_frame_mode` low `crc_fcs` reads 0.
- R2: A cycle with `frame_start` or `sw_clear` high loads the register with the preset: zero when `cfg_start_ones` is 0, or all ones across the selected width when it is 1. This takes precedence over a data bit presented in the same cycle, and that bit is discarded.
- R3: `cfg_type` selects the polynomial: 00 is x^16+x^12+x^5+1, 01 is x^16+x^15+x^2+1, and 10 is the 32-bit Ethernet polynomial. Code 11 must not be presented. Each included bit updates the register in reflected form, least significant data bit first. Register bit 0 holds the coefficient of x^(W-1).
- R4: `char_incl` is sampled on the bit that carries `char_begin`. That sample governs that bit and every following bit up to the next `char_begin`. Bits of an excluded character leave the register unchanged.
- R5: With `cfg_frame_mode` high and type 00 or 10, `crc_fcs` is the one's complement of the register across the selected width. In every other case `crc_fcs` equals the register. Type 01 is never complemented.
- R6: With `cfg_frame_mode` high, `crc_good` is high exactly when the register reads F0B8 hex for type 00. For type 10 the required register reading is DEBB20E3 hex, which is C704DD7B hex written with x^31 as the most significant bit.
- R7: With `cfg_frame_mode` low, or with type 01, `crc_good` is high exactly when the register is zero across the selected width.
- R8: `fcs_load` snapshots `crc_fcs`. `fcs_bit` first shows bit 0, the x^(W-1) term, and each `fcs_shift` advances one bit toward higher bit positions. `fcs_active` stays high for exactly W shifts: 16 for types 00 and 01, and 32 for type 10.
- R9: With a 16-bit type selected, bits 31..16 of `crc_fcs` read zero after any preset or update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_type | input | 2 | Polynomial selector (00 CCITT, 01 CRC-16, 10 32-bit) |
| cfg_start_ones | input | 1 | Preset value: 0 all zeros, 1 all ones |
| cfg_frame_mode | input | 1 | Complemented check value and fixed-residue checking |
| frame_start | input | 1 | Frame boundary strobe; presets the register |
| sw_clear | input | 1 | Software clear strobe; presets the register |
| bit_valid | input | 1 | A data bit is presented this cycle |
| bit_in | input | 1 | Serial data bit |
| char_begin | input | 1 | This bit is the first of a character |
| char_incl | input | 1 | Inclusion flag, sampled with char_begin |
| fcs_load | input | 1 | Snapshot the check value for serial output |
| fcs_shift | input | 1 | Advance the serial output by one bit |
| crc_fcs | output | 32 | Check value to transmit, bit 0 sent first |
| fcs_bit | output | 1 | Current serial check bit |
| fcs_active | output | 1 | Serial check bits remain to be sent |
| crc_good | output | 1 | Received remainder is valid for the mode |

## Verification
The checker assumes three things about the inputs. `cfg_type` never carries the reserved code 11. The configuration stays fixed between a preset and the end of the frame that follows it. The checker also predicts the register only from ports, so it expects the preset and hold behaviour to be visible one cycle after each strobe. The bench changes configuration only while `bit_valid` is low, and it always raises `frame_start` before the first data bit. It uses only the three defined codes. Any shifting of the check value is finished before the next load, and the bench then checks that `fcs_active` drops.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

   typedef enum logic [1:0] {
      CRC_CCITT = 2'b00,
      CRC_16    = 2'b01,
      CRC_32    = 2'b10,
      CRC_RSVD  = 2'b11
   } crc_kind_e;

   localparam int unsigned REG_W = 32;
   localparam int unsigned NARROW_W = 16;

   // reflected generator polynomials
   localparam logic [REG_W-1:0] POLY_CCITT_R = 32'h0000_8408;
   localparam logic [REG_W-1:0] POLY_16_R    = 32'h0000_A001;
   localparam logic [REG_W-1:0] POLY_32_R    = 32'hEDB8_8320;

   // valid residues seen in the reflected register
   localparam logic [REG_W-1:0] RESID_CCITT  = 32'h0000_F0B8;
   localparam logic [REG_W-1:0] RESID_32     = 32'hDEBB_20E3;

   function automatic logic [REG_W-1:0] width_mask(input crc_kind_e k);
      return (k == CRC_32) ? {REG_W{1'b1}} : {{(REG_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   endfunction

endpackage

// File: rtl/crc_char_gate.sv
module crc_char_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic char_begin,
   input  logic char_incl,
   output logic take
);
   logic incl_q;
   logic incl_now;

   always_comb begin
      incl_now = char_begin ? char_incl : incl_q;
      take     = bit_valid & incl_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     incl_q <= 1'b0;
      else if (bit_valid && char_begin) incl_q <= char_incl;
   end
endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
   import crc_serial_pkg::*;
#(
   parameter int SUPPORT_WIDE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  crc_kind_e        kind,
   input  logic             start_ones,
   input  logic             clear,
   input  logic             take,
   input  logic             din,
   output logic [REG_W-1:0] reg_q
);
   crc_kind_e        kind_eff;
   logic             fb;
   logic [REG_W-1:0] narrow_sh;
   logic [REG_W-1:0] nxt;
   logic [REG_W-1:0] preset;

   generate
      if (SUPPORT_WIDE != 0) begin : g_wide
         logic [REG_W-1:0] wide_sh;
         always_comb begin
            kind_eff = kind;
            wide_sh  = {1'b0, reg_q[REG_W-1:1]};
         end
         always_comb begin
            if (kind_eff == CRC_32) nxt = wide_sh ^ (fb ? POLY_32_R : '0);
            else                    nxt = narrow_sh ^ (fb ? ((kind_eff == CRC_16) ? POLY_16_R : POLY_CCITT_R) : '0);
         end
      end else begin : g_narrow
         always_comb begin
            kind_eff = (kind == CRC_32) ? CRC_CCITT : kind;
            nxt = narrow_sh ^ (fb ? ((kind_eff == CRC_16) ? POLY_16_R : POLY_CCITT_R) : '0);
         end
      end
   endgenerate

   always_comb begin
      fb        = reg_q[0] ^ din;
      narrow_sh = {{(REG_W-NARROW_W){1'b0}}, 1'b0, reg_q[NARROW_W-1:1]};
      preset    = start_ones ? width_mask(kind_eff) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     reg_q <= '0;
      else if (clear) reg_q <= preset;
      else if (take)  reg_q <= nxt;
   end
endmodule

// File: rtl/crc_frame_view.sv
module crc_frame_view
   import crc_serial_pkg::*;
#(
   parameter int SUPPORT_WIDE = 1
) (
   input  crc_kind_e        kind,
   input  logic             frame_mode,
   input  logic [REG_W-1:0] reg_q,
   output logic [REG_W-1:0] fcs,
   output logic             good,
   output logic [5:0]       fcs_len
);
   crc_kind_e        kind_eff;
   logic [REG_W-1:0] mask;
   logic             invert;

   always_comb begin
      kind_eff = (SUPPORT_WIDE == 0 && kind == CRC_32) ? CRC_CCITT : kind;
      mask     = width_mask(kind_eff);
      invert   = frame_mode && (kind_eff != CRC_16);
      fcs      = (invert ? ~reg_q : reg_q) & mask;
      fcs_len  = (kind_eff == CRC_32) ? 6'd32 : 6'd16;
      if (!invert)                good = ((reg_q & mask) == '0);
      else if (kind_eff == CRC_32) good = (reg_q == RESID_32);
      else                         good = (reg_q[NARROW_W-1:0] == RESID_CCITT[NARROW_W-1:0]);
   end
endmodule

// File: rtl/crc_fcs_shifter.sv
module crc_fcs_shifter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] value,
   input  logic [5:0]   len,
   output logic         bit_out,
   output logic         active
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sh_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= value;
         cnt_q <= CW'(len);
      end else if (shift && cnt_q != '0) begin
         sh_q  <= {1'b0, sh_q[W-1:1]};
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      bit_out = sh_q[0];
      active  = (cnt_q != '0);
   end
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
   import crc_serial_pkg::*;
#(
   parameter int SUPPORT_WIDE = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  cfg_type,
   input  logic        cfg_start_ones,
   input  logic        cfg_frame_mode,
   input  logic        frame_start,
   input  logic        sw_clear,
   input  logic        bit_valid,
   input  logic        bit_in,
   input  logic        char_begin,
   input  logic        char_incl,
   input  logic        fcs_load,
   input  logic        fcs_shift,
   output logic [31:0] crc_fcs,
   output logic        fcs_bit,
   output logic        fcs_active,
   output logic        crc_good
);
   generate
      if (SUPPORT_WIDE != 0 && SUPPORT_WIDE != 1) begin : g_bad_param
         $error("SUPPORT_WIDE must be 0 or 1");
      end
      if (REG_W != 32) begin : g_bad_width
         $error("register width must be 32");
      end
   endgenerate

   crc_kind_e        kind;
   logic             take;
   logic             clear;
   logic [REG_W-1:0] crc_reg;
   logic [5:0]       fcs_len;

   always_comb begin
      kind  = crc_kind_e'(cfg_type);
      clear = frame_start | sw_clear;
   end

   crc_char_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_valid  (bit_valid),
      .char_begin (char_begin),
      .char_incl  (char_incl),
      .take       (take)
   );

   crc_lfsr_core #(.SUPPORT_WIDE(SUPPORT_WIDE)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .start_ones (cfg_start_ones),
      .clear      (clear),
      .take       (take),
      .din        (bit_in),
      .reg_q      (crc_reg)
   );

   crc_frame_view #(.SUPPORT_WIDE(SUPPORT_WIDE)) u_view (
      .kind       (kind),
      .frame_mode (cfg_frame_mode),
      .reg_q      (crc_reg),
      .fcs        (crc_fcs),
      .good       (crc_good),
      .fcs_len    (fcs_len)
   );

   crc_fcs_shifter #(.W(REG_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fcs_load),
      .shift   (fcs_shift),
      .value   (crc_fcs),
      .len     (fcs_len),
      .bit_out (fcs_bit),
      .active  (fcs_active)
   );
endmodule

// File: rtl/crc_serial_engine_chk.sv
module crc_serial_engine_chk #(
   parameter int SUPPORT_WIDE = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  cfg_type,
   input logic        cfg_start_ones,
   input logic        frame_start,
   input logic        sw_clear,
   input logic        bit_valid,
   input logic        char_begin,
   input logic        char_incl,
   input logic        fcs_load,
   input logic        fcs_active,
   input logic [31:0] crc_reg
);
   logic [31:0] mask_now;
   always_comb mask_now = (cfg_type == 2'b10 && SUPPORT_WIDE != 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;

   // R3
   cfg_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_valid |-> cfg_type != 2'b11);

   // R2
   preset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start || sw_clear) |=> crc_reg == ($past(cfg_start_ones) ? $past(mask_now) : 32'h0));

   // R4
   excluded_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && char_begin && !char_incl && !frame_start && !sw_clear) |=> $stable(crc_reg));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && !frame_start && !sw_clear) |=> $stable(crc_reg));

   // R8
   load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fcs_load |=> fcs_active);

   // R8
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fcs_active && !fcs_load) |=> !fcs_active);

   // R9
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((frame_start || sw_clear) && cfg_type != 2'b10) |=> crc_reg[31:16] == 16'h0);
endmodule

bind crc_serial_engine crc_serial_engine_chk #(.SUPPORT_WIDE(SUPPORT_WIDE)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_type       (cfg_type),
   .cfg_start_ones (cfg_start_ones),
   .frame_start    (frame_start),
   .sw_clear       (sw_clear),
   .bit_valid      (bit_valid),
   .char_begin     (char_begin),
   .char_incl      (char_incl),
   .fcs_load       (fcs_load),
   .fcs_active     (fcs_active),
   .crc_reg        (crc_reg)
);

// File: tb/crc_serial_engine_test.sv
module crc_serial_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_type = 2'b00;
   logic        cfg_start_ones = 1'b0;
   logic        cfg_frame_mode = 1'b0;
   logic        frame_start = 1'b0;
   logic        sw_clear = 1'b0;
   logic        bit_valid = 1'b0;
   logic        bit_in = 1'b0;
   logic        char_begin = 1'b0;
   logic        char_incl = 1'b0;
   logic        fcs_load = 1'b0;
   logic        fcs_shift = 1'b0;
   logic [31:0] crc_fcs;
   logic        fcs_bit;
   logic        fcs_active;
   logic        crc_good;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   crc_serial_engine uut (
      .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_start_ones(cfg_start_ones),
      .cfg_frame_mode(cfg_frame_mode), .frame_start(frame_start), .sw_clear(sw_clear),
      .bit_valid(bit_valid), .bit_in(bit_in), .char_begin(char_begin), .char_incl(char_incl),
      .fcs_load(fcs_load), .fcs_shift(fcs_shift), .crc_fcs(crc_fcs), .fcs_bit(fcs_bit),
      .fcs_active(fcs_active), .crc_good(crc_good)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // behavioural model in normal (non-reflected) polynomial order
   function automatic int wid(input logic [1:0] t);
      return (t == 2'b10) ? 32 : 16;
   endfunction

   function automatic logic [31:0] poly_n(input logic [1:0] t);
      if (t == 2'b10) return 32'h04C1_1DB7;
      if (t == 2'b01) return 32'h0000_8005;
      return 32'h0000_1021;
   endfunction

   function automatic logic [31:0] wmask(input logic [1:0] t);
      return (t == 2'b10) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
   endfunction

   function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [1:0] t, input logic d);
      logic fbk;
      logic [31:0] n;
      fbk = c[wid(t)-1] ^ d;
      n = (c << 1) & wmask(t);
      if (fbk) n = n ^ poly_n(t);
      return n;
   endfunction

   function automatic logic [31:0] ref_byte(input logic [31:0] c, input logic [1:0] t, input logic [7:0] b);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) r = ref_step(r, t, b[i]);
      return r;
   endfunction

   function automatic logic [31:0] ref_tx(input logic [31:0] c, input logic [1:0] t, input bit fm);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < wid(t); i++) r[i] = c[wid(t)-1-i];
      if (fm && t != 2'b01) r = ~r & wmask(t);
      return r;
   endfunction

   task automatic idle();
      @(negedge clk);
      bit_valid = 1'b0; char_begin = 1'b0; char_incl = 1'b0; bit_in = 1'b0;
      frame_start = 1'b0; sw_clear = 1'b0; fcs_load = 1'b0; fcs_shift = 1'b0;
   endtask

   task automatic send_bit(input logic b, input logic first, input logic incl);
      @(negedge clk);
      bit_valid = 1'b1; bit_in = b; char_begin = first; char_incl = incl;
   endtask

   // inclusion flag driven inverted on later bits: only the first bit's flag counts
   task automatic send_byte(input logic [7:0] b, input logic incl);
      for (int i = 0; i < 8; i++) send_bit(b[i], i == 0, (i == 0) ? incl : ~incl);
   endtask

   task automatic start_frame(input logic [1:0] t, input bit ones, input bit fm);
      @(negedge clk);
      cfg_type = t; cfg_start_ones = ones; cfg_frame_mode = fm;
      frame_start = 1'b1;
      idle();
   endtask

   // transmit, shift out and receive one frame with the given settings
   task automatic run_frame(input logic [1:0] t, input bit ones, input bit fm, input int nb, input logic [7:0] base);
      logic [31:0] c;
      logic [31:0] exp;
      logic [31:0] got;
      string rq;
      rq = fm ? "R6" : "R7";
      if (t == 2'b01) rq = "R7";
      c = ones ? wmask(t) : 32'h0;
      start_frame(t, ones, fm);
      for (int i = 0; i < nb; i++) begin
         send_byte(base + 8'(i * 37), 1'b1);
         c = ref_byte(c, t, base + 8'(i * 37));
      end
      idle();
      exp = ref_tx(c, t, fm);
      check(crc_fcs == exp, "R3/R5 check value", crc_fcs, exp);
      // R8 serial output
      @(negedge clk); fcs_load = 1'b1;
      @(negedge clk); fcs_load = 1'b0;
      got = '0;
      for (int k = 0; k < wid(t); k++) begin
         if (k > 0) @(negedge clk);
         got[k] = fcs_bit & fcs_active;
         fcs_shift = 1'b1;
      end
      @(negedge clk); fcs_shift = 1'b0;
      check(got == exp, "R8 serial bits", got, exp);
      check(!fcs_active, "R8 active after W shifts", {31'h0, fcs_active}, 32'h0);
      // receive the frame plus its check bits
      start_frame(t, ones, fm);
      for (int i = 0; i < nb; i++) send_byte(base + 8'(i * 37), 1'b1);
      for (int k = 0; k < wid(t); k++) send_bit(exp[k], (k % 8) == 0, 1'b1);
      idle();
      check(crc_good, rq, {31'h0, crc_good}, 32'h1);
      // corrupted reception
      start_frame(t, ones, fm);
      for (int i = 0; i < nb; i++) send_byte((base + 8'(i * 37)) ^ ((i == 0) ? 8'h04 : 8'h00), 1'b1);
      for (int k = 0; k < wid(t); k++) send_bit(exp[k], (k % 8) == 0, 1'b1);
      idle();
      check(!crc_good, {rq, " corrupted"}, {31'h0, crc_good}, 32'h0);
   endtask

   task automatic test_reset();
      check(crc_fcs == 32'h0, "R1 register", crc_fcs, 32'h0);
      check(!fcs_active, "R1 fcs_active", {31'h0, fcs_active}, 32'h0);
   endtask

   task automatic test_inclusion();
      logic [31:0] c;
      c = 32'h0000_FFFF;
      start_frame(2'b00, 1'b1, 1'b0);
      send_byte(8'hA5, 1'b1); c = ref_byte(c, 2'b00, 8'hA5);
      send_byte(8'h3C, 1'b0);
      send_byte(8'h7E, 1'b1); c = ref_byte(c, 2'b00, 8'h7E);
      idle();
      check(crc_fcs == ref_tx(c, 2'b00, 1'b0), "R4 excluded character", crc_fcs, ref_tx(c, 2'b00, 1'b0));
   endtask

   task automatic test_clear_priority();
      start_frame(2'b01, 1'b0, 1'b0);
      send_byte(8'h5A, 1'b1);
      @(negedge clk);
      frame_start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1; char_begin = 1'b1; char_incl = 1'b1;
      idle();
      check(crc_fcs == 32'h0, "R2 clear beats data bit", crc_fcs, 32'h0);
      start_frame(2'b00, 1'b1, 1'b0);
      send_byte(8'h11, 1'b1);
      @(negedge clk); sw_clear = 1'b1;
      idle();
      check(crc_fcs == 32'h0000_FFFF, "R2 software clear to ones", crc_fcs, 32'h0000_FFFF);
   endtask

   task automatic test_narrow_upper();
      start_frame(2'b10, 1'b1, 1'b0);
      send_byte(8'hC3, 1'b1);
      idle();
      start_frame(2'b00, 1'b1, 1'b0);
      check(crc_fcs == 32'h0000_FFFF, "R9 upper half zero", crc_fcs, 32'h0000_FFFF);
      start_frame(2'b10, 1'b1, 1'b1);
      check(crc_fcs == 32'h0, "R5 complemented ones preset", crc_fcs, 32'h0);
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      for (int t = 0; t < 3; t++)
         for (int fm = 0; fm < 2; fm++)
            for (int ones = 0; ones < 2; ones++)
               run_frame(2'(t), ones[0], fm[0], 3 + t + fm, 8'(8'h1F + 8'(t * 53 + fm * 11 + ones * 7)));
      test_inclusion();
      test_clear_priority();
      test_narrow_upper();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule